// File: doc/BRIEF.md
# Forty-bit multiply-accumulate datapath

This block is the arithmetic core of a 16-bit-operand multiply-accumulate unit. It has a 40-bit accumulator. Two 32-bit source words arrive on each strobe. From each word the block takes either its upper or its lower half-word and widens it to 32 bits. The unsigned operation zero-extends the half-word, and every other operation sign-extends it. The block then multiplies the two values. The 32-bit product either replaces the accumulator or is added to or subtracted from it. Each update completes in a single clock.

The accumulator is presented as two 32-bit registers. The low register holds bits 31:0. The high register holds the guard bits 39:32, sign-extended to a full word. Software-style direct writes load either register from a shared data bus. A write to the high register keeps only the low byte of the data and sign-extends it. An arithmetic strobe in the same cycle as a direct write takes precedence.

Top module: `mac40_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `acc_lo` and `acc_hi` to zero.
- R2: Operand 1 comes from `src_a` and operand 2 from `src_b`. `half_sel[0]` picks the half-word for operand 1 and `half_sel[1]` picks it for operand 2. A select bit of 1 takes bits 31:16 and a select bit of 0 takes bits 15:0.
- R3: When `op_code` is 2'b00 (unsigned multiply), the chosen half-words are zero-extended. For every other code they are sign-extended.
- R4: `op_code` 2'b00: `acc_lo` receives the low 32 bits of the product and `acc_hi` becomes zero.
- R5: `op_code` 2'b01 (signed multiply): `acc_lo` receives the product and every bit of `acc_hi` equals product bit 31.
- R6: `op_code` 2'b10 (multiply-add): the sign-extended product is added to the 40-bit value {acc_hi[7:0], acc_lo}, wrapping modulo 2^40. `acc_lo` gets result bits 31:0. `acc_hi` gets bits 39:32 sign-extended to 32 bits.
- R7: `op_code` 2'b11 (multiply-subtract): same as R6, but the sign-extended product is subtracted.
- R8: Every arithmetic update is visible on the outputs right after the rising edge at which `op_valid` was sampled high.
- R9: With `op_valid` low, `wr_lo_en` loads `wr_data` into `acc_lo`. `wr_hi_en` loads `wr_data[7:0]` sign-extended to 32 bits into `acc_hi`. The two enables may be used together.
- R10: With `op_valid`, `wr_lo_en` and `wr_hi_en` all low, both registers keep their values whatever the other inputs do.
- R11: When `op_valid` is high, the arithmetic result is stored and any direct write in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Arithmetic update strobe |
| op_code | input | 2 | 00 unsigned mul, 01 signed mul, 10 mul-add, 11 mul-sub |
| half_sel | input | 2 | Bit 0: operand 1 upper half; bit 1: operand 2 upper half |
| src_a | input | 32 | Source word for operand 1 |
| src_b | input | 32 | Source word for operand 2 |
| wr_lo_en | input | 1 | Direct write of the low register |
| wr_hi_en | input | 1 | Direct write of the high register |
| wr_data | input | 32 | Data for direct writes |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| acc_hi | output | 32 | Accumulator bits 39:32, sign-extended |

## Verification
All state lives in the two output registers, so a wrong internal value shows at the ports on the edge after the faulty update. Faults in the guard byte are the exception. Such a fault can stay hidden until a multiply-add or multiply-subtract carries across bit 32, or until a value with bit 39 set is loaded. Errors in half-word selection or extension show only for operands whose chosen half has bit 15 set, or whose other half differs. The directed cases therefore use such operands, and they wrap the accumulator at the 40-bit boundary in both directions.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
  // Arithmetic update selected by op_code.
  typedef enum logic [1:0] {
    OP_UMUL = 2'b00,
    OP_SMUL = 2'b01,
    OP_MADD = 2'b10,
    OP_MSUB = 2'b11
  } mac_op_e;

  function automatic logic op_is_signed(input mac_op_e op);
    return op != OP_UMUL;
  endfunction
endpackage

// File: rtl/mac40_opsel.sv
module mac40_opsel #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  logic              upper,
  input  logic              is_signed,
  output logic [WORD_W-1:0] ext
);
  localparam int HALF_W = WORD_W / 2;

  function automatic logic [WORD_W-1:0] widen_half(
    input logic [WORD_W-1:0] w, input logic up, input logic sgn);
    logic [HALF_W-1:0] h;
    h = up ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    return {{(WORD_W-HALF_W){sgn & h[HALF_W-1]}}, h};
  endfunction

  assign ext = widen_half(word, upper, is_signed);

  // R3
  always_comb begin
    zero_ext_chk: assert (is_signed || ext[WORD_W-1:HALF_W] == '0);
  end
endmodule

// File: rtl/mac40_arith.sv
module mac40_arith
  import mac40_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int GUARD_W = 8
) (
  input  mac_op_e            op,
  input  logic [WORD_W-1:0]  m1,
  input  logic [WORD_W-1:0]  m2,
  input  logic [WORD_W-1:0]  cur_lo,
  input  logic [GUARD_W-1:0] cur_g,
  output logic [WORD_W-1:0]  prod,
  output logic [WORD_W-1:0]  nxt_lo,
  output logic [GUARD_W-1:0] nxt_g
);
  localparam int ACC_W = WORD_W + GUARD_W;

  function automatic logic [ACC_W-1:0] acc_step(
    input mac_op_e op_i, input logic [WORD_W-1:0] p,
    input logic [ACC_W-1:0] acc);
    logic [ACC_W-1:0] p_sx;
    p_sx = {{GUARD_W{p[WORD_W-1]}}, p};
    case (op_i)
      OP_UMUL: return {{GUARD_W{1'b0}}, p};
      OP_SMUL: return p_sx;
      OP_MADD: return acc + p_sx;
      default: return acc - p_sx;
    endcase
  endfunction

  logic [ACC_W-1:0] nxt_acc;

  // widened operands make the truncated product correct for both signednesses
  assign prod    = m1 * m2;
  assign nxt_acc = acc_step(op, prod, {cur_g, cur_lo});
  assign nxt_lo  = nxt_acc[WORD_W-1:0];
  assign nxt_g   = nxt_acc[ACC_W-1:WORD_W];
endmodule

// File: rtl/mac40_accreg.sv
module mac40_accreg #(
  parameter int WORD_W  = 32,
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd,
  input  logic [WORD_W-1:0]  nxt_lo,
  input  logic [GUARD_W-1:0] nxt_g,
  input  logic               wr_lo_en,
  input  logic               wr_hi_en,
  input  logic [WORD_W-1:0]  wr_data,
  output logic [WORD_W-1:0]  q_lo,
  output logic [GUARD_W-1:0] q_g
);
  logic load_lo, load_g;
  assign load_lo = !upd && wr_lo_en;
  assign load_g  = !upd && wr_hi_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_lo <= '0;
      q_g  <= '0;
    end else if (upd) begin
      q_lo <= nxt_lo;
      q_g  <= nxt_g;
    end else begin
      if (load_lo) q_lo <= wr_data;
      if (load_g)  q_g  <= wr_data[GUARD_W-1:0];
    end
  end

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd && !wr_lo_en && !wr_hi_en) |=> ($stable(q_lo) && $stable(q_g)));

  // R11
  upd_wins_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> (q_lo == $past(nxt_lo) && q_g == $past(nxt_g)));

  // R9
  lo_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd && wr_lo_en) |=> q_lo == $past(wr_data));

  // R9
  g_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd && wr_hi_en) |=> q_g == $past(wr_data[GUARD_W-1:0]));
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
  import mac40_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int GUARD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [1:0]        half_sel,
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  input  logic              wr_lo_en,
  input  logic              wr_hi_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] acc_lo,
  output logic [WORD_W-1:0] acc_hi
);
  localparam int N_OPND = 2;
  localparam int EXT_W  = WORD_W - GUARD_W;

  mac_op_e            op;
  logic               sgn;
  logic [WORD_W-1:0]  srcs [N_OPND];
  logic [WORD_W-1:0]  opnd [N_OPND];
  logic [WORD_W-1:0]  prod, nxt_lo;
  logic [GUARD_W-1:0] nxt_g, q_g;

  assign op      = mac_op_e'(op_code);
  assign sgn     = op_is_signed(op);
  assign srcs[0] = src_a;
  assign srcs[1] = src_b;

  for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
    mac40_opsel #(.WORD_W(WORD_W)) u_sel (
      .word(srcs[i]), .upper(half_sel[i]), .is_signed(sgn), .ext(opnd[i]));
  end

  mac40_arith #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_arith (
    .op(op), .m1(opnd[0]), .m2(opnd[1]), .cur_lo(acc_lo), .cur_g(q_g),
    .prod(prod), .nxt_lo(nxt_lo), .nxt_g(nxt_g));

  mac40_accreg #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_acc (
    .clk(clk), .rst(rst), .upd(op_valid), .nxt_lo(nxt_lo), .nxt_g(nxt_g),
    .wr_lo_en(wr_lo_en), .wr_hi_en(wr_hi_en), .wr_data(wr_data),
    .q_lo(acc_lo), .q_g(q_g));

  assign acc_hi = {{EXT_W{q_g[GUARD_W-1]}}, q_g};

  // R4
  umul_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_UMUL) |=> (acc_hi == '0 && acc_lo == $past(prod)));

  // R5
  smul_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_SMUL) |=> acc_hi == {WORD_W{acc_lo[WORD_W-1]}});

  // R6
  madd_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_MADD) |=>
      acc_lo == $past(acc_lo) + $past(prod));
endmodule

// File: tb/tb_mac40_unit.sv
module tb_mac40_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, op_valid, wr_lo_en, wr_hi_en;
  logic [1:0]  op_code, half_sel;
  logic [31:0] src_a, src_b, wr_data, acc_lo, acc_hi;
  logic [31:0] exp_lo, exp_hi;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac40_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .half_sel(half_sel), .src_a(src_a), .src_b(src_b),
    .wr_lo_en(wr_lo_en), .wr_hi_en(wr_hi_en), .wr_data(wr_data),
    .acc_lo(acc_lo), .acc_hi(acc_hi));

  // Reference: 64-bit arithmetic on {high word, low word}.
  function automatic void model(input logic v, input logic [1:0] op,
    input logic [1:0] sel, input logic [31:0] a, input logic [31:0] b,
    input logic wl, input logic wh, input logic [31:0] wd);
    longint x1, x2, p;
    logic [63:0] pv, acc, t;
    if (!v) begin
      if (wl) exp_lo = wd;
      if (wh) exp_hi = wd[7] ? (32'hFFFFFF00 | wd[7:0]) : {24'h0, wd[7:0]};
      return;
    end
    x1 = sel[0] ? longint'(a >> 16) : longint'(a & 32'hFFFF);
    x2 = sel[1] ? longint'(b >> 16) : longint'(b & 32'hFFFF);
    if (op != 2'b00) begin
      if (x1 >= 32768) x1 -= 65536;
      if (x2 >= 32768) x2 -= 65536;
    end
    p = x1 * x2;
    pv = p;
    case (op)
      2'b00: begin exp_lo = pv[31:0]; exp_hi = 0; end
      2'b01: begin exp_lo = pv[31:0]; exp_hi = pv[31] ? 32'hFFFFFFFF : 0; end
      default: begin
        acc = {exp_hi, exp_lo};
        pv = {{32{pv[31]}}, pv[31:0]};
        t = (op == 2'b10) ? acc + pv : acc - pv;
        exp_lo = t[31:0];
        exp_hi = t[39] ? (32'hFFFFFF00 | t[39:32]) : {24'h0, t[39:32]};
      end
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] lo_e,
                       input logic [31:0] hi_e);
    n_chk++;
    if (acc_lo !== lo_e || acc_hi !== hi_e) begin
      n_fail++;
      $display("FAIL %s: acc_lo=%h acc_hi=%h expected lo=%h hi=%h",
               tag, acc_lo, acc_hi, lo_e, hi_e);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] op,
    input logic [1:0] sel, input logic [31:0] a, input logic [31:0] b,
    input logic wl, input logic wh, input logic [31:0] wd);
    @(negedge clk);
    op_valid = v; op_code = op; half_sel = sel; src_a = a; src_b = b;
    wr_lo_en = wl; wr_hi_en = wh; wr_data = wd;
    @(posedge clk);
    #1;
    model(v, op, sel, a, b, wl, wh, wd);
  endtask

  task automatic idle();
    step(0, 2'b00, 2'b00, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    rst = 1;
    idle();
    check("R1 reset state", 0, 0);
    exp_lo = 0; exp_hi = 0;
    rst = 0;
  endtask

  task automatic t_unsigned();
    step(1, 2'b00, 2'b00, 32'h1234FFFF, 32'h0001FFFF, 0, 0, 0);
    check("R3 R4 R8 unsigned low halves", 32'hFFFE0001, 0);
    step(1, 2'b00, 2'b11, 32'h8000FFFF, 32'h0003FFFF, 0, 0, 0);
    check("R2 R4 unsigned upper halves", 32'h00018000, 0);
  endtask

  task automatic t_signed();
    step(1, 2'b01, 2'b00, 32'h7777FFFF, 32'hFFFF0002, 0, 0, 0);
    check("R3 R5 signed negative", 32'hFFFFFFFE, 32'hFFFFFFFF);
    step(1, 2'b01, 2'b01, 32'h0005FFFF, 32'hFFFF0003, 0, 0, 0);
    check("R2 R5 mixed halves", 32'h0000000F, 0);
    step(1, 2'b01, 2'b10, 32'hFFFF8000, 32'h8000FFFF, 0, 0, 0);
    check("R5 min times min", 32'h40000000, 0);
  endtask

  task automatic t_accumulate();
    step(0, 2'b00, 2'b00, 0, 0, 1, 1, 32'h0000007F);
    step(0, 2'b00, 2'b00, 0, 0, 1, 0, 32'hFFFFFFFF);
    check("R9 preload", 32'hFFFFFFFF, 32'h0000007F);
    step(1, 2'b10, 2'b00, 32'h00000001, 32'h00000001, 0, 0, 0);
    check("R6 wrap into sign", 0, 32'hFFFFFF80);
    step(1, 2'b11, 2'b00, 32'h00000001, 32'h00000001, 0, 0, 0);
    check("R7 borrow back", 32'hFFFFFFFF, 32'h0000007F);
    step(1, 2'b00, 2'b00, 0, 0, 0, 0, 0);
    step(1, 2'b11, 2'b00, 32'h00000003, 32'h00000004, 0, 0, 0);
    check("R7 below zero", 32'hFFFFFFF4, 32'hFFFFFFFF);
    step(1, 2'b10, 2'b00, 32'h0000FFFF, 32'h00000002, 0, 0, 0);
    check("R6 negative product", 32'hFFFFFFF2, 32'hFFFFFFFF);
    step(0, 2'b00, 2'b00, 0, 0, 1, 1, 32'h00000080);
    step(1, 2'b10, 2'b00, 32'h0000FFFF, 32'h00000001, 0, 0, 0);
    check("R6 carry stays in 40 bits", 32'h0000007F, 32'hFFFFFF80);
  endtask

  task automatic t_write();
    step(0, 2'b00, 2'b00, 0, 0, 0, 1, 32'h12345680);
    check("R9 high keeps byte", 32'h0000007F, 32'hFFFFFF80);
    step(0, 2'b00, 2'b00, 0, 0, 1, 0, 32'hCAFE0123);
    check("R9 low write", 32'hCAFE0123, 32'hFFFFFF80);
    step(0, 2'b00, 2'b00, 0, 0, 0, 1, 32'hFFFFFF7F);
    check("R9 high positive byte", 32'hCAFE0123, 32'h0000007F);
  endtask

  task automatic t_hold();
    step(0, 2'b10, 2'b11, 32'hFFFFFFFF, 32'h12345678, 0, 0, 32'hDEADBEEF);
    check("R10 hold 1", 32'hCAFE0123, 32'h0000007F);
    step(0, 2'b01, 2'b01, 32'h80008000, 32'h7FFF7FFF, 0, 0, 32'h0);
    check("R10 hold 2", 32'hCAFE0123, 32'h0000007F);
  endtask

  task automatic t_priority();
    step(1, 2'b00, 2'b00, 32'h00000006, 32'h00000007, 1, 1, 32'hAAAAAA80);
    check("R11 arithmetic over write", 32'h0000002A, 0);
  endtask

  task automatic t_midreset();
    step(0, 2'b00, 2'b00, 0, 0, 1, 1, 32'h55555585);
    rst = 1;
    step(1, 2'b10, 2'b00, 32'h3, 32'h3, 0, 0, 0);
    check("R1 reset mid-run", 0, 0);
    exp_lo = 0; exp_hi = 0;
    rst = 0;
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[3:0] != 0, r[5:4], r[7:6], $urandom, $urandom,
           r[8], r[9], $urandom);
      check("R6 R7 random sequence", exp_lo, exp_hi);
    end
  endtask

  initial begin
    rst = 1; op_valid = 0; op_code = 0; half_sel = 0; src_a = 0; src_b = 0;
    wr_lo_en = 0; wr_hi_en = 0; wr_data = 0; exp_lo = 0; exp_hi = 0;
    t_reset();
    t_unsigned();
    t_signed();
    t_accumulate();
    t_write();
    t_hold();
    t_priority();
    t_midreset();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule